// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block receives asynchronous serial frames from one line. A tick input runs at sixteen times the bit rate. In idle, the block waits for the line to go low. It confirms the start bit at the middle of the bit. It then takes each data bit, least significant first, as a majority vote of three samples around the bit centre. An optional parity bit follows the data bits. At the centre of the first stop bit, the block copies the assembled word into a holding register and raises a ready flag. It then returns to idle at once, so a second stop bit from the sender needs no handling.

The frame configuration is captured when a start bit is detected. It has a data length of five to eight bits and a parity mode of none, even or odd. A one-cycle read strobe from the consumer takes the word and drops the ready flag. The parity-fault and stop-fault flags belong to the word in the holding register. While the enable is low, the block ignores the line and reports that it does not own the pin.

Top module: `serial_frame_rx`

## Requirements
- R1: A low level seen on a tick in idle is a start candidate. It becomes a frame only if the line is still low at the 8th tick after it. Otherwise the receiver goes back to idle and loads nothing.
- R2: Data bits arrive least significant bit first. Each bit is the majority of the line samples taken at ticks 7, 8 and 9 of its bit period, so a glitch that spoils a single sample does not change the bit.
- R3: `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The word is right-aligned in `rx_word`, and every bit above the data length reads as zero.
- R4: `par_sel` sets the parity mode. A value of 0 or 1 means no parity bit. A value of 2 means even parity: the data bits and the parity bit together hold an even count of ones. A value of 3 means odd parity. `par_fault` is set with the word when the received parity bit breaks the selected rule, and is 0 when there is no parity bit.
- R5: `stop_fault` is set with the word when the first stop bit is voted low. The word is loaded in that case too.
- R6: The word is loaded and `word_ready` rises at the centre of the first stop bit. Frames with one or two stop bits, and frames sent back to back, are all received.
- R7: A pulse on `take` drops `word_ready` on the next clock. `rx_word` and the fault flags keep their values until the next load. If a load and `take` fall in the same cycle, the load wins.
- R8: While `rx_en` is low, no frame is received and `pin_owned` is 0. Dropping `rx_en` in the middle of a frame abandons that frame.
- R9: After reset, `word_ready`, `par_fault` and `stop_fault` are 0, and `rx_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| rx_en | input | 1 | receiver enable |
| rx_line | input | 1 | serial input line, idles high |
| os_tick | input | 1 | one-cycle pulse at 16x the bit rate |
| len_sel | input | 2 | data length select (5 + value bits) |
| par_sel | input | 2 | parity mode: 0/1 none, 2 even, 3 odd |
| take | input | 1 | read strobe, one cycle |
| rx_word | output | 8 | received word, right-aligned |
| word_ready | output | 1 | a word is waiting to be read |
| par_fault | output | 1 | parity fault of the held word |
| stop_fault | output | 1 | stop-bit fault of the held word |
| pin_owned | output | 1 | receiver currently owns the line input |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and a two-stage input synchronizer. It drives a tick every 4 clocks, so one bit lasts 64 clocks. With this spacing, a two-clock glitch in the middle of a bit can spoil at most one of the three voted samples, which tests the majority rule directly. A 12-clock low pulse ends well before the start-bit midpoint, which tests the false-start rejection. The bench covers all four data lengths, both parity senses with good and bad parity, a low stop bit, one and two stop bits, back-to-back frames, and enable changes both between frames and during a frame.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_sel,
  input  logic       take,
  output logic [7:0] rx_word,
  output logic       word_ready,
  output logic       par_fault,
  output logic       stop_fault,
  output logic       pin_owned
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] T_A   = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] T_MID = CW'(OVS/2);
  localparam logic [CW-1:0] T_C   = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] T_END = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt;
  logic [2:0]      bit_n;
  logic [7:0]      sh;
  logic [1:0]      len_q, par_q;
  logic            v_a, v_b, pacc, pbit;

  wire rx_s      = sync_q[SYNC-1];
  wire vote      = (v_a & v_b) | (v_a & rx_s) | (v_b & rx_s);
  wire decide    = os_tick && (cnt == T_C);
  wire last_data = (bit_n == (3'd4 + {1'b0, len_q}));
  wire load_buf  = rx_en && (st == S_STOP) && decide;
  wire busy      = (st != S_IDLE);

  assign pin_owned = rx_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bit_n <= '0; sh <= '0;
      len_q <= '0; par_q <= '0; v_a <= 1'b1; v_b <= 1'b1;
      pacc <= 1'b0; pbit <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else if (os_tick) begin
      cnt <= (cnt == T_END) ? '0 : cnt + 1'b1;
      if (cnt == T_A)   v_a <= rx_s;
      if (cnt == T_MID) v_b <= rx_s;
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st <= S_START; cnt <= CW'(1);
            len_q <= len_sel; par_q <= par_sel;
            sh <= '0; pacc <= 1'b0; bit_n <= '0;
          end
        S_START: begin
          if (cnt == T_MID && rx_s) st <= S_IDLE;
          else if (cnt == T_END)    st <= S_DATA;
        end
        S_DATA: begin
          if (cnt == T_C) begin
            sh   <= {vote, sh[7:1]};
            pacc <= pacc ^ vote;
          end
          if (cnt == T_END) begin
            if (last_data) st <= par_q[1] ? S_PAR : S_STOP;
            else           bit_n <= bit_n + 3'd1;
          end
        end
        S_PAR: begin
          if (cnt == T_C)   pbit <= vote;
          if (cnt == T_END) st <= S_STOP;
        end
        S_STOP:
          if (cnt == T_C) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0; word_ready <= 1'b0; par_fault <= 1'b0; stop_fault <= 1'b0;
    end else if (load_buf) begin
      rx_word    <= sh >> (2'd3 - len_q);
      word_ready <= 1'b1;
      par_fault  <= par_q[1] && (pbit != (pacc ^ par_q[0]));
      stop_fault <= !vote;
    end else if (take) begin
      word_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       take,
  input logic       word_ready,
  input logic [7:0] rx_word,
  input logic       par_fault,
  input logic       stop_fault,
  input logic       load_buf,
  input logic       busy,
  input logic [1:0] len_q
);
  AST_READY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> $past(load_buf)); // R6
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load_buf) |=> !word_ready); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_buf |=> $stable(rx_word)); // R7
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_buf |=> ((rx_word >> (4'd5 + {2'b00, $past(len_q)})) == 8'd0)); // R3
  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy); // R8
  AST_STOP_FAULT_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_fault) |-> $past(load_buf)); // R5
  AST_PAR_FAULT_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_fault) |-> $past(load_buf)); // R4
endmodule

bind serial_frame_rx serial_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .take(take),
  .word_ready(word_ready), .rx_word(rx_word), .par_fault(par_fault),
  .stop_fault(stop_fault), .load_buf(load_buf), .busy(busy), .len_q(len_q)
);

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic clk = 0, rst_n = 0, rx_en = 0, rx_line = 1, os_tick = 0, take = 0;
  logic [1:0] len_sel = 2'd3, par_sel = 2'd0;
  logic [7:0] rx_word;
  logic word_ready, par_fault, stop_fault, pin_owned;
  int total = 0, bad = 0;
  bit finished = 0;

  serial_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line), .os_tick(os_tick),
    .len_sel(len_sel), .par_sel(par_sel), .take(take), .rx_word(rx_word),
    .word_ready(word_ready), .par_fault(par_fault), .stop_fault(stop_fault),
    .pin_owned(pin_owned)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_bit_glitch(input logic b);
    rx_line = b;
    repeat (30) @(negedge clk);
    rx_line = ~b;
    repeat (2) @(negedge clk);
    rx_line = b;
    repeat (BIT_CLK - 32) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input logic [1:0] pm,
                            input int nstop, input bit flip_par, input logic stop_v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < n; i++) p ^= d[i];
    if (pm[0]) p = ~p;
    len_sel = 2'(n - 5);
    par_sel = pm;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (pm[1]) send_bit(p ^ flip_par);
    send_bit(stop_v);
    for (int i = 1; i < nstop; i++) send_bit(1'b1);
    rx_line = 1'b1;
  endtask

  task automatic do_take();
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [7:0] w, input logic pe, input logic fe);
    check({req, " ready"}, word_ready, 1);
    check({req, " word"}, rx_word, w);
    check({req, " par_fault"}, par_fault, pe);
    check({req, " stop_fault"}, stop_fault, fe);
    do_take();
  endtask

  task automatic t_reset();
    check("R9 ready", word_ready, 0);
    check("R9 word", rx_word, 0);
    check("R9 faults", {par_fault, stop_fault}, 0);
    check("R8 not owned", pin_owned, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 8, 2'd0, 1, 0, 1); expect_word("R2 A5", 8'hA5, 0, 0);
    send_frame(8'h01, 8, 2'd0, 1, 0, 1); expect_word("R2 01", 8'h01, 0, 0);
    send_frame(8'hFE, 8, 2'd1, 1, 0, 1); expect_word("R4 mode1 none", 8'hFE, 0, 0);
  endtask

  task automatic t_lengths();
    send_frame(8'hFF, 5, 2'd0, 1, 0, 1); expect_word("R3 len5", 8'h1F, 0, 0);
    send_frame(8'hEA, 6, 2'd0, 1, 0, 1); expect_word("R3 len6", 8'h2A, 0, 0);
    send_frame(8'hC3, 7, 2'd0, 1, 0, 1); expect_word("R3 len7", 8'h43, 0, 0);
  endtask

  task automatic t_parity();
    send_frame(8'h37, 8, 2'd2, 1, 0, 1); expect_word("R4 even ok", 8'h37, 0, 0);
    send_frame(8'h37, 8, 2'd2, 1, 1, 1); expect_word("R4 even bad", 8'h37, 1, 0);
    send_frame(8'h15, 6, 2'd3, 1, 0, 1); expect_word("R4 odd ok", 8'h15, 0, 0);
    send_frame(8'h15, 6, 2'd3, 1, 1, 1); expect_word("R4 odd bad", 8'h15, 1, 0);
  endtask

  task automatic t_framing();
    send_frame(8'h42, 8, 2'd0, 1, 0, 0);
    expect_word("R5 low stop", 8'h42, 0, 1);
    repeat (2 * BIT_CLK) @(negedge clk);
    check("R5 no extra frame", word_ready, 0);
    send_frame(8'h42, 8, 2'd0, 1, 0, 1); expect_word("R5 good stop", 8'h42, 0, 0);
  endtask

  task automatic t_false_start();
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    check("R1 false start ignored", word_ready, 0);
    send_frame(8'h3C, 8, 2'd0, 1, 0, 1); expect_word("R1 after false start", 8'h3C, 0, 0);
  endtask

  task automatic t_glitch();
    len_sel = 2'd3; par_sel = 2'd0;
    send_bit(1'b0);
    send_bit(1'b1); send_bit_glitch(1'b0); send_bit_glitch(1'b1); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit_glitch(1'b1); send_bit(1'b0);
    send_bit(1'b1);
    expect_word("R2 glitch vote", 8'h65, 0, 0);
  endtask

  task automatic t_stops();
    send_frame(8'h81, 8, 2'd0, 2, 0, 1); expect_word("R6 two stops", 8'h81, 0, 0);
    send_frame(8'h7E, 8, 2'd2, 1, 0, 1); expect_word("R6 back2back a", 8'h7E, 0, 0);
    send_frame(8'h19, 8, 2'd2, 1, 0, 1); expect_word("R6 back2back b", 8'h19, 0, 0);
  endtask

  task automatic t_take();
    send_frame(8'h5A, 8, 2'd0, 1, 0, 1);
    check("R7 ready before take", word_ready, 1);
    do_take();
    check("R7 ready dropped", word_ready, 0);
    check("R7 word held", rx_word, 8'h5A);
    do_take();
    check("R7 word after extra take", rx_word, 8'h5A);
  endtask

  task automatic t_enable();
    rx_en = 1'b0;
    @(negedge clk);
    check("R8 pin released", pin_owned, 0);
    send_frame(8'h55, 8, 2'd0, 1, 0, 1);
    repeat (BIT_CLK) @(negedge clk);
    check("R8 disabled no frame", word_ready, 0);
    rx_en = 1'b1;
    @(negedge clk);
    check("R8 pin owned", pin_owned, 1);
    len_sel = 2'd3; par_sel = 2'd0;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    rx_en = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b1);
    rx_en = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    check("R8 aborted frame", word_ready, 0);
    send_frame(8'hC6, 8, 2'd0, 1, 0, 1); expect_word("R8 after abort", 8'hC6, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    t_basic();
    t_lengths();
    t_parity();
    t_framing();
    t_false_start();
    t_glitch();
    t_stops();
    t_take();
    t_enable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule